// File: doc/BRIEF.md
# Bidirectional Latch/Register Bus Transceiver

This block joins two parallel data buses, side A and side B, with an independent storage path in each direction. Each path holds one storage element that behaves either as a transparent latch or as an edge-triggered register, depending on its controls. The selected value is presented on the opposite side, or that side is released. The A-to-B and B-to-A paths share no state.

Each path has four controls: a latch enable, a capture strobe, an active-low strobe enable and an active-low output enable. The block is synchronous to a single system clock `clk`. The capture strobe is treated as a data input sampled on `clk`. A strobe rise is a strobe seen high on a `clk` edge after it was low on the previous edge. The transparent route from input to output is combinational.

Each side has separate input and output vectors and a per-bit drive-enable vector, so the block stays free of tri-state logic. A pad ring or a top-level wrapper maps these onto bidirectional pins. When a side is released, its output vector reads all zeros so that outputs can be merged with an OR. The data width `W` is a parameter with a default of 18.

Top module: `bidir_hold_xcvr`

## Requirements
- R1: When a path's latch enable is 1, that path's output equals its source input in the same cycle, with no clock edge needed.
- R2: On every `clk` edge where the latch enable is 1, the storage element loads the source. After the latch enable falls, the output holds the source value from the last such edge, even if the strobe is high when the latch enable falls.
- R3: With the latch enable at 0 and the strobe enable at 0, a strobe rise (strobe 1 on this `clk` edge, 0 on the previous one) loads the source into storage. The output shows the new value after that edge.
- R4: With the latch enable at 0, a strobe that stays steady at 1 or at 0 leaves the stored value and the output unchanged.
- R5: With the latch enable at 0 and the strobe enable at 1, strobe rises are ignored. Enabling the strobe later while the strobe is already high does not count as a rise.
- R6: Output enable at 1 makes the path's drive-enable vector all zeros and its output vector all zeros, whatever the other controls are. Output enable at 0 makes the drive-enable vector all ones. The output enable never affects storage.
- R7: The B-to-A path obeys R1 to R6 with its own controls, and activity on one path never changes the other path's output.
- R8: A synchronous reset with `rst_n` at 0 clears both stored values to zero and clears the strobe history to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous reset, active low |
| a_in | input | W | Data arriving on side A |
| a_out | output | W | Data for side A from the B-to-A path |
| a_drv | output | W | Per-bit drive enable for side A |
| b_in | input | W | Data arriving on side B |
| b_out | output | W | Data for side B from the A-to-B path |
| b_drv | output | W | Per-bit drive enable for side B |
| ab_le | input | 1 | A-to-B latch enable (1 = transparent) |
| ab_strobe | input | 1 | A-to-B capture strobe |
| ab_ce_n | input | 1 | A-to-B strobe enable, active low |
| ab_oe_n | input | 1 | A-to-B output enable, active low |
| ba_le | input | 1 | B-to-A latch enable (1 = transparent) |
| ba_strobe | input | 1 | B-to-A capture strobe |
| ba_ce_n | input | 1 | B-to-A strobe enable, active low |
| ba_oe_n | input | 1 | B-to-A output enable, active low |

## Verification
The properties assume that all controls and data change only between `clk` edges. They assume each strobe level lasts at least one full `clk` period, so that every rise is seen on exactly one edge. They also assume the strobe is low while reset is asserted, so the first edge after reset cannot count as a rise. The stimulus meets these assumptions by updating every input one nanosecond after a rising `clk` edge, holding each strobe level for at least one period, and keeping both strobes low throughout reset.

// File: rtl/xcvr_pkg.sv
// Shared types for the bidirectional latch/register transceiver.
// Assumes: nothing beyond IEEE 1800-2017 packages.
package xcvr_pkg;

    // Number of independent transfer directions (A-to-B, B-to-A).
    localparam int NUM_DIR = 2;

    // Index of each direction in the per-direction arrays.
    typedef enum int {
        DIR_AB = 0,
        DIR_BA = 1
    } dir_idx_t;

    // Control bundle of one direction.
    typedef struct packed {
        logic le;      // 1 = transparent
        logic strobe;  // capture strobe, sampled on clk
        logic ce_n;    // strobe enable, active low
        logic oe_n;    // output enable, active low
    } path_ctl_t;

endpackage

// File: rtl/xfer_edge_detect.sv
// Rise detector for a capture strobe sampled on the system clock.
// Assumes: strobe changes away from clk edges; each strobe level lasts
// at least one clk period. History clears to 0 on reset.
module xfer_edge_detect (
    input  logic clk,
    input  logic rst_n,
    input  logic strobe,
    output logic rise
);

    logic strobe_q;

    // Remember the strobe level seen at the previous clk edge.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            strobe_q <= 1'b0;
        end else begin
            strobe_q <= strobe;
        end
    end

    // A rise is high now and low at the previous edge.
    always_comb begin
        rise = strobe & ~strobe_q;
    end

endmodule

// File: rtl/xfer_store.sv
// Storage element of one direction: tracks the source while
// transparent, captures it on an enabled strobe rise otherwise.
// Assumes: rise comes from xfer_edge_detect on the same clock.
module xfer_store #(
    parameter int W = 18
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         le,
    input  logic         ce_n,
    input  logic         rise,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);

    logic load;

    // Decide whether this edge loads the source.
    always_comb begin
        load = le | (~ce_n & rise);
    end

    // Hold or load the stored word; clear on reset.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            q <= '0;
        end else if (load) begin
            q <= d;
        end
    end

endmodule

// File: rtl/xfer_drive.sv
// Output stage of one direction: picks live or stored data and gates
// the side's value and per-bit drive enable with the output enable.
// Assumes: a released side must read all zeros for OR merging.
module xfer_drive #(
    parameter int W = 18
) (
    input  logic         le,
    input  logic         oe_n,
    input  logic [W-1:0] live,
    input  logic [W-1:0] held,
    output logic [W-1:0] dout,
    output logic [W-1:0] drv
);

    logic [W-1:0] pick;

    // Transparent mode shows the live source, otherwise the stored word.
    always_comb begin
        pick = le ? live : held;
    end

    // Gate value and drive enable with the active-low output enable.
    always_comb begin
        dout = oe_n ? '0 : pick;
        drv  = {W{~oe_n}};
    end

endmodule

// File: rtl/xfer_path.sv
// One transfer direction: rise detector, storage element, output stage.
// Assumes: ctl fields are synchronous to clk apart from the
// combinational transparent route.
module xfer_path
    import xcvr_pkg::*;
#(
    parameter int W = 18
) (
    input  logic         clk,
    input  logic         rst_n,
    input  path_ctl_t    ctl,
    input  logic [W-1:0] src,
    output logic [W-1:0] dout,
    output logic [W-1:0] drv
);

    logic         rise;
    logic [W-1:0] held;

    xfer_edge_detect u_edge (
        .clk    (clk),
        .rst_n  (rst_n),
        .strobe (ctl.strobe),
        .rise   (rise)
    );

    xfer_store #(.W(W)) u_store (
        .clk   (clk),
        .rst_n (rst_n),
        .le    (ctl.le),
        .ce_n  (ctl.ce_n),
        .rise  (rise),
        .d     (src),
        .q     (held)
    );

    xfer_drive #(.W(W)) u_drive (
        .le   (ctl.le),
        .oe_n (ctl.oe_n),
        .live (src),
        .held (held),
        .dout (dout),
        .drv  (drv)
    );

endmodule

// File: rtl/bidir_hold_xcvr.sv
// Bidirectional latch/register transceiver between sides A and B.
// Two independent paths, each with its own latch enable, strobe,
// strobe enable and output enable. Tri-state mapping is left to the
// pad wrapper through the per-bit drive enables.
// Assumes: one system clock; synchronous active-low reset.
module bidir_hold_xcvr
    import xcvr_pkg::*;
#(
    parameter int W = 18
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] a_in,
    output logic [W-1:0] a_out,
    output logic [W-1:0] a_drv,
    input  logic [W-1:0] b_in,
    output logic [W-1:0] b_out,
    output logic [W-1:0] b_drv,
    input  logic         ab_le,
    input  logic         ab_strobe,
    input  logic         ab_ce_n,
    input  logic         ab_oe_n,
    input  logic         ba_le,
    input  logic         ba_strobe,
    input  logic         ba_ce_n,
    input  logic         ba_oe_n
);

    path_ctl_t    ctl  [NUM_DIR];
    logic [W-1:0] src  [NUM_DIR];
    logic [W-1:0] dout [NUM_DIR];
    logic [W-1:0] drv  [NUM_DIR];

    // Gather per-direction controls and sources.
    always_comb begin
        ctl[DIR_AB] = '{le: ab_le, strobe: ab_strobe, ce_n: ab_ce_n, oe_n: ab_oe_n};
        ctl[DIR_BA] = '{le: ba_le, strobe: ba_strobe, ce_n: ba_ce_n, oe_n: ba_oe_n};
        src[DIR_AB] = a_in;
        src[DIR_BA] = b_in;
    end

    for (genvar d = 0; d < NUM_DIR; d++) begin : g_dir
        xfer_path #(.W(W)) u_path (
            .clk   (clk),
            .rst_n (rst_n),
            .ctl   (ctl[d]),
            .src   (src[d]),
            .dout  (dout[d]),
            .drv   (drv[d])
        );
    end

    // A-to-B path feeds side B, B-to-A path feeds side A.
    always_comb begin
        b_out = dout[DIR_AB];
        b_drv = drv[DIR_AB];
        a_out = dout[DIR_BA];
        a_drv = drv[DIR_BA];
    end

endmodule

// File: rtl/xfer_dir_check.sv
// Property checker for one transfer direction, bound twice to the top.
// Assumes: inputs change away from clk edges; strobe low during reset.
module xfer_dir_check #(
    parameter int W = 18
) (
    input logic         clk,
    input logic         rst_n,
    input logic [W-1:0] src,
    input logic [W-1:0] dst_out,
    input logic [W-1:0] dst_drv,
    input logic         le,
    input logic         strobe,
    input logic         ce_n,
    input logic         oe_n
);

    logic [1:0] age;

    // Count edges since reset (saturating) to guard $past depth.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            age <= 2'd0;
        end else if (age != 2'd3) begin
            age <= age + 2'd1;
        end
    end

    a_r1_transparent: assert property (@(posedge clk) disable iff (!rst_n)
        (le && !oe_n) |-> (dst_out == src));

    a_r3_capture: assert property (@(posedge clk) disable iff (!rst_n)
        ((age >= 2'd2) && $past(!le && !ce_n && strobe) && !$past(strobe, 2)
         && !le && !oe_n) |-> (dst_out == $past(src)));

    a_r4_hold_low: assert property (@(posedge clk) disable iff (!rst_n)
        ((age >= 2'd1) && !le && !oe_n && $past(!le && !oe_n && !strobe))
        |-> (dst_out == $past(dst_out)));

    a_r4_hold_high: assert property (@(posedge clk) disable iff (!rst_n)
        ((age >= 2'd2) && !le && !oe_n && $past(!le && !oe_n && strobe)
         && $past(strobe, 2)) |-> (dst_out == $past(dst_out)));

    a_r5_ce_block: assert property (@(posedge clk) disable iff (!rst_n)
        ((age >= 2'd1) && !le && !oe_n && $past(!le && !oe_n && ce_n))
        |-> (dst_out == $past(dst_out)));

    a_r6_release: assert property (@(posedge clk) disable iff (!rst_n)
        oe_n |-> ((dst_drv == '0) && (dst_out == '0)));

    a_r6_drive: assert property (@(posedge clk) disable iff (!rst_n)
        !oe_n |-> (dst_drv == '1));

    a_r8_reset_clear: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(!rst_n) && !le && !oe_n) |-> (dst_out == '0));

endmodule

// R7: the same checker covers each direction on its own signals.
bind bidir_hold_xcvr xfer_dir_check #(.W(W)) chk_ab (
    .clk(clk), .rst_n(rst_n), .src(a_in), .dst_out(b_out), .dst_drv(b_drv),
    .le(ab_le), .strobe(ab_strobe), .ce_n(ab_ce_n), .oe_n(ab_oe_n)
);

bind bidir_hold_xcvr xfer_dir_check #(.W(W)) chk_ba (
    .clk(clk), .rst_n(rst_n), .src(b_in), .dst_out(a_out), .dst_drv(a_drv),
    .le(ba_le), .strobe(ba_strobe), .ce_n(ba_ce_n), .oe_n(ba_oe_n)
);

// File: tb/bidir_hold_xcvr_test.sv
// Directed bench for bidir_hold_xcvr: one task per scenario.
module bidir_hold_xcvr_test;

    localparam int W = 18;
    localparam logic [W-1:0] ONES = '1;

    logic         clk = 1'b0;
    logic         rst_n;
    logic [W-1:0] a_in, b_in;
    logic [W-1:0] a_out, a_drv, b_out, b_drv;
    logic         ab_le, ab_strobe, ab_ce_n, ab_oe_n;
    logic         ba_le, ba_strobe, ba_ce_n, ba_oe_n;

    int n_tests = 0;
    int n_fail  = 0;
    bit done    = 1'b0;

    always #4 clk = ~clk;

    bidir_hold_xcvr uut (
        .clk(clk), .rst_n(rst_n),
        .a_in(a_in), .a_out(a_out), .a_drv(a_drv),
        .b_in(b_in), .b_out(b_out), .b_drv(b_drv),
        .ab_le(ab_le), .ab_strobe(ab_strobe), .ab_ce_n(ab_ce_n), .ab_oe_n(ab_oe_n),
        .ba_le(ba_le), .ba_strobe(ba_strobe), .ba_ce_n(ba_ce_n), .ba_oe_n(ba_oe_n)
    );

    task automatic tick();
        @(posedge clk);
        #1;
    endtask

    task automatic chk(input string req, input logic [W-1:0] got, input logic [W-1:0] exp);
        n_tests++;
        if (got !== exp) begin
            n_fail++;
            $display("FAIL %s: got %h expected %h", req, got, exp);
        end
    endtask

    task automatic t_reset();
        rst_n = 1'b0;
        a_in = '0; b_in = '0;
        ab_le = 1'b0; ab_strobe = 1'b0; ab_ce_n = 1'b1; ab_oe_n = 1'b0;
        ba_le = 1'b0; ba_strobe = 1'b0; ba_ce_n = 1'b1; ba_oe_n = 1'b0;
        a_in = 18'h3ABCD; b_in = 18'h1DCBA;
        repeat (3) tick();
        rst_n = 1'b1;
        tick();
        chk("R8 b_out after reset", b_out, '0);
        chk("R8 a_out after reset", a_out, '0);
        chk("R6 b_drv enabled", b_drv, ONES);
        chk("R6 a_drv enabled", a_drv, ONES);
    endtask

    task automatic t_transparent();
        ab_le = 1'b1;
        a_in = 18'h15A5A;
        #1 chk("R1 follow first", b_out, 18'h15A5A);
        a_in = 18'h2C3C3;
        #1 chk("R1 follow second", b_out, 18'h2C3C3);
        tick();
    endtask

    task automatic t_le_fall();
        a_in = 18'h0F0F1;
        ab_strobe = 1'b1;
        tick();
        ab_le = 1'b0;
        a_in = 18'h3FFFF;
        #1 chk("R2 hold after le fall, strobe high", b_out, 18'h0F0F1);
        tick(); tick();
        chk("R4 strobe steady high", b_out, 18'h0F0F1);
        ab_strobe = 1'b0;
        tick(); tick();
        chk("R4 strobe steady low", b_out, 18'h0F0F1);
    endtask

    task automatic t_clocked();
        ab_ce_n = 1'b0;
        a_in = 18'h12345;
        ab_strobe = 1'b1;
        tick();
        chk("R3 capture on rise", b_out, 18'h12345);
        a_in = 18'h00ABC;
        tick();
        chk("R4 no capture while high", b_out, 18'h12345);
        ab_strobe = 1'b0;
        tick();
        chk("R4 no capture on fall", b_out, 18'h12345);
    endtask

    task automatic t_ce_block();
        ab_ce_n = 1'b1;
        a_in = 18'h2468A;
        ab_strobe = 1'b1;
        tick();
        chk("R5 rise ignored", b_out, 18'h12345);
        ab_ce_n = 1'b0;
        tick();
        chk("R5 late enable no rise", b_out, 18'h12345);
        ab_strobe = 1'b0;
        tick();
        ab_strobe = 1'b1;
        tick();
        chk("R3 capture after re-arm", b_out, 18'h2468A);
    endtask

    task automatic t_hiz();
        ab_oe_n = 1'b1;
        ab_le = 1'b1;
        #1 chk("R6 released out zero", b_out, '0);
        chk("R6 released drv zero", b_drv, '0);
        ab_le = 1'b0;
        ab_strobe = 1'b0;
        tick();
        a_in = 18'h1B2B3;
        ab_strobe = 1'b1;
        tick();
        chk("R6 drv zero while clocked", b_drv, '0);
        ab_oe_n = 1'b0;
        #1 chk("R6 storage kept while released", b_out, 18'h1B2B3);
        chk("R6 drv back on", b_drv, ONES);
    endtask

    task automatic t_ba();
        ba_le = 1'b1;
        b_in = 18'h33333;
        #1 chk("R7 R1 B-to-A transparent", a_out, 18'h33333);
        tick();
        ba_le = 1'b0;
        b_in = 18'h01010;
        #1 chk("R7 R2 B-to-A hold", a_out, 18'h33333);
        ba_ce_n = 1'b0;
        ba_strobe = 1'b1;
        tick();
        chk("R7 R3 B-to-A capture", a_out, 18'h01010);
        chk("R7 A-to-B untouched", b_out, 18'h1B2B3);
        ba_oe_n = 1'b1;
        #1 chk("R7 R6 B-to-A released", a_out, '0);
        chk("R7 R6 a_drv zero", a_drv, '0);
        chk("R7 b_drv unaffected", b_drv, ONES);
    endtask

    initial begin
        t_reset();
        t_transparent();
        t_le_fall();
        t_clocked();
        t_ce_block();
        t_hiz();
        t_ba();
        if (!done) begin
            done = 1'b1;
            $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

    initial begin
        #(8 * 20000);
        if (!done) begin
            done = 1'b1;
            n_tests++;
            n_fail++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

endmodule